// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block takes eight active-low, level-sensitive PCI interrupt lines (named A to H) and steers each one onto a 16-line active-high IRQ bus that feeds a legacy interrupt controller. Each line has its own route byte, written through a simple register write port. The byte either names a target IRQ or leaves the line unrouted. Any number of lines may land on the same IRQ. Their requests are inverted to active high and ORed together.

Internal interrupt sources are wired by parameter to one PCI line each. While a source is high, its line counts as asserted, exactly as if the external pin were low. From that point it is routed like any other request. An IRQ that has at least one PCI line routed to it stops passing the legacy serial-IRQ request for that number. The IRQ outputs are combinational from the pins and the stored route bytes. A write changes those bytes at the next rising clock edge.

Top module: `pci_irq_steer`

## Requirements
- R1: After reset, every route byte holds 80h. No PCI line or internal source drives any IRQ, and each `irq_out` bit equals the matching `legacy_irq` bit.
- R2: A write with `cfg_addr` 60h, 61h, 62h or 63h sets the route byte of line A, B, C or D. A write to 68h, 69h, 6Ah or 6Bh sets line E, F, G or H. A write to any other address changes no route byte.
- R3: A line whose route is enabled asserts `irq_out[n]` high while its `pci_int_n` bit is low, where n is bits 3:0 of its route byte. The same output falls when the pin goes high, provided nothing else asserts it.
- R4: Only IRQ numbers 3, 4, 5, 6, 7, 9, 10, 11, 12, 14 and 15 are legal targets. A route byte that names any other number leaves its line unrouted.
- R5: A route byte with bit 7 set leaves its line unrouted. A byte with any of bits 6:4 set does the same.
- R6: When several enabled lines share one IRQ, that output is high while any one of them is asserted.
- R7: An IRQ with at least one enabled line routed to it ignores `legacy_irq` for that number. The output follows only the routed lines.
- R8: While internal source s is high, PCI line `SRC_LINE[s]` counts as asserted, whatever its pin level. Source 0 defaults to line A and source 1 to line D.
- R9: A write reaches the outputs only after the rising clock edge that samples `cfg_we`. Until that edge, `irq_out` reflects the old route byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the route registers |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Route register write strobe |
| cfg_addr | input | 8 | Write address, 60h–63h and 68h–6Bh |
| cfg_wdata | input | 8 | Route byte: bit 7 off, bits 6:4 zero, bits 3:0 IRQ |
| pci_int_n | input | 8 | PCI interrupt lines A (bit 0) to H (bit 7), active low |
| int_src | input | 2 | Internal interrupt sources, active high |
| legacy_irq | input | 16 | Legacy serial-IRQ requests, active high |
| irq_out | output | 16 | IRQ bus to the interrupt controller, active high |

## Verification
A route byte stored at the wrong line or with a wrong value has two effects at the ports. It moves a PCI request onto a wrong IRQ, and it unblocks or blocks the legacy request on another IRQ. The effect shows combinationally, in the same cycle as the first write that stores the bad byte. Such a fault stays hidden only while every pin and legacy input it touches is idle. The bench therefore toggles pins and legacy requests on every step. The bench also checks the output half a clock before and after each write edge, which exposes a register that updates too early or too late.

// File: rtl/pci_steer_pkg.sv
package pci_steer_pkg;

    // Route byte: off=1 or nonzero rsvd leaves the line unrouted.
    typedef struct packed {
        logic       off;
        logic [2:0] rsvd;
        logic [3:0] num;
    } route_t;

    localparam route_t ROUTE_RESET = '{off: 1'b1, rsvd: 3'd0, num: 4'd0};

    // IRQs 3-7, 9-12, 14, 15 are legal targets.
    localparam logic [15:0] LEGAL_IRQ_MASK = 16'hDEF8;

endpackage

// File: rtl/pci_route_regs.sv
module pci_route_regs
    import pci_steer_pkg::*;
#(
    parameter int unsigned        NUM_LINES = 8,
    parameter int unsigned        ADDR_W    = 8,
    parameter logic [ADDR_W-1:0]  BASE_LO   = 8'h60,
    parameter logic [ADDR_W-1:0]  BASE_HI   = 8'h68
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [7:0]                     wdata,
    output route_t [NUM_LINES-1:0]         route_o
);
    localparam int unsigned HALF   = NUM_LINES / 2;
    localparam int unsigned HALF_W = $clog2(HALF);
    localparam int unsigned IDX_W  = $clog2(NUM_LINES);

    typedef struct packed {
        route_t [NUM_LINES-1:0] route;
    } regs_s;

    regs_s            state_d, state_q;
    logic             hit_lo, hit_hi;
    logic [IDX_W-1:0] idx;

    always_comb begin
        state_d = state_q;
        hit_lo  = (addr[ADDR_W-1:HALF_W] == BASE_LO[ADDR_W-1:HALF_W]);
        hit_hi  = (addr[ADDR_W-1:HALF_W] == BASE_HI[ADDR_W-1:HALF_W]);
        idx     = {hit_hi, addr[HALF_W-1:0]};
        if (we && (hit_lo || hit_hi)) begin
            state_d.route[idx] = route_t'(wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < NUM_LINES; l++) begin
                state_q.route[l] <= ROUTE_RESET;
            end
        end else begin
            state_q <= state_d;
        end
    end

    assign route_o = state_q.route;

    // R1: first cycle out of reset, all routes are disabled
    a_r1_reset_routes: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (state_q.route == {NUM_LINES{ROUTE_RESET}}));

    // R9: a decoded write lands at the next edge
    a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (hit_lo || hit_hi)) |=> (route_o[$past(idx)] == route_t'($past(wdata))));

    // R2: no write strobe, no change
    a_r2_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(route_o));

endmodule

// File: rtl/pci_line_merge.sv
module pci_line_merge #(
    parameter int unsigned NUM_LINES = 8,
    parameter int unsigned NUM_SRC   = 2,
    parameter int unsigned SRC_LINE [NUM_SRC] = '{0, 3}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pci_int_n,
    input  logic [NUM_SRC-1:0]   int_src,
    output logic [NUM_LINES-1:0] line_act
);
    logic [NUM_LINES-1:0] src_hits;

    always_comb begin
        src_hits = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (int_src[s]) src_hits[SRC_LINE[s]] = 1'b1;
        end
        line_act = ~pci_int_n | src_hits;
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src_chk
        // R8: an internal source forces its line active
        a_r8_src_asserts_line: assert property (@(posedge clk) disable iff (!rst_n)
            int_src[s] |-> line_act[SRC_LINE[s]]);
    end

endmodule

// File: rtl/pci_route_decode.sv
module pci_route_decode
    import pci_steer_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  route_t             route,
    output logic [NUM_IRQ-1:0] claim
);
    logic enabled;

    always_comb begin
        enabled = !route.off && (route.rsvd == 3'd0) && LEGAL_IRQ_MASK[route.num];
        claim   = '0;
        if (enabled) claim[route.num] = 1'b1;
    end

    // R4: a claim only ever points at a legal IRQ, at most one
    a_r4_legal_only: assert property (@(posedge clk) disable iff (!rst_n)
        ((claim & ~LEGAL_IRQ_MASK[NUM_IRQ-1:0]) == '0) && $onehot0(claim));

    // R5: the off bit always silences the line
    a_r5_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        route.off |-> (claim == '0));

endmodule

// File: rtl/pci_irq_steer.sv
module pci_irq_steer
    import pci_steer_pkg::*;
#(
    parameter int unsigned NUM_LINES = 8,
    parameter int unsigned NUM_IRQ   = 16,
    parameter int unsigned NUM_SRC   = 2,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned SRC_LINE [NUM_SRC] = '{0, 3}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [7:0]           cfg_wdata,
    input  logic [NUM_LINES-1:0] pci_int_n,
    input  logic [NUM_SRC-1:0]   int_src,
    input  logic [NUM_IRQ-1:0]   legacy_irq,
    output logic [NUM_IRQ-1:0]   irq_out
);
    route_t [NUM_LINES-1:0]                 route;
    logic   [NUM_LINES-1:0]                 line_act;
    logic   [NUM_LINES-1:0][NUM_IRQ-1:0]    claim;
    logic   [NUM_IRQ-1:0]                   claimed, drive;

    pci_route_regs #(
        .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W),
        .BASE_LO(ADDR_W'(8'h60)), .BASE_HI(ADDR_W'(8'h68))
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .route_o(route)
    );

    pci_line_merge #(
        .NUM_LINES(NUM_LINES), .NUM_SRC(NUM_SRC), .SRC_LINE(SRC_LINE)
    ) u_merge (
        .clk(clk), .rst_n(rst_n), .pci_int_n(pci_int_n),
        .int_src(int_src), .line_act(line_act)
    );

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        pci_route_decode #(.NUM_IRQ(NUM_IRQ)) u_dec (
            .clk(clk), .rst_n(rst_n), .route(route[l]), .claim(claim[l])
        );

        // R3 / R6: an active, routed line always raises its IRQ
        a_r6_shared_or: assert property (@(posedge clk) disable iff (!rst_n)
            line_act[l] |-> ((irq_out & claim[l]) == claim[l]));
    end

    always_comb begin
        claimed = '0;
        drive   = '0;
        for (int l = 0; l < NUM_LINES; l++) begin
            claimed = claimed | claim[l];
            if (line_act[l]) drive = drive | claim[l];
        end
        irq_out = drive | (legacy_irq & ~claimed);
    end

    // R7: a claimed IRQ with no active routed line stays low
    a_r7_legacy_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (claimed & ~drive & irq_out) == '0);

endmodule

// File: tb/pci_irq_steer_bench.sv
module pci_irq_steer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  pci_int_n = 8'hFF;
    logic [1:0]  int_src = '0;
    logic [15:0] legacy_irq = '0;
    logic [15:0] irq_out;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] model [8];

    localparam logic [15:0] LEGAL = 16'hDEF8;

    always #10 clk = ~clk;

    pci_irq_steer u_pci_irq_steer (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pci_int_n(pci_int_n), .int_src(int_src),
        .legacy_irq(legacy_irq), .irq_out(irq_out)
    );

    function automatic int line_of(input logic [7:0] a);
        if (a >= 8'h60 && a <= 8'h63) return int'(a - 8'h60);
        if (a >= 8'h68 && a <= 8'h6B) return int'(a - 8'h68) + 4;
        return -1;
    endfunction

    function automatic logic [15:0] expect_irq();
        logic [15:0] drv = '0;
        logic [15:0] clm = '0;
        for (int l = 0; l < 8; l++) begin
            logic act;
            act = !pci_int_n[l] || (l == 0 && int_src[0]) || (l == 3 && int_src[1]);
            if (!model[l][7] && model[l][6:4] == 3'd0 && LEGAL[model[l][3:0]]) begin
                clm[model[l][3:0]] = 1'b1;
                if (act) drv[model[l][3:0]] = 1'b1;
            end
        end
        return drv | (legacy_irq & ~clm);
    endfunction

    task automatic check(input string tag, input logic [15:0] exp);
        n_run++;
        if (irq_out !== exp) begin
            n_fail++;
            $display("FAIL %s irq_out=%h expected=%h", tag, irq_out, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        if (line_of(a) >= 0) model[line_of(a)] = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic settle_check(input string tag);
        #2;
        check(tag, expect_irq());
    endtask

    initial begin
        for (int l = 0; l < 8; l++) model[l] = 8'h80;
        void'($urandom(32'd7341));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        pci_int_n = 8'h00; int_src = 2'b11; legacy_irq = 16'hA5C3;
        #2 check("R1 reset passes legacy", 16'hA5C3);

        wr(8'h60, 8'h05);
        pci_int_n = 8'hFE; legacy_irq = 16'h0000;
        settle_check("R2 R3 line A to IRQ5");
        check("R3 IRQ5 high", 16'h0020);
        pci_int_n = 8'hFF; int_src = 2'b00;
        settle_check("R3 pin released");

        wr(8'h6B, 8'h0F);
        pci_int_n = 8'h7F;
        settle_check("R2 line H to IRQ15");
        wr(8'h64, 8'h03);
        pci_int_n = 8'h00; legacy_irq = 16'h0008;
        settle_check("R2 stray address ignored");

        wr(8'h62, 8'h08);
        pci_int_n = 8'hFB; legacy_irq = 16'h0100;
        settle_check("R4 illegal IRQ8 unrouted");
        check("R4 legacy 8 still passes", 16'h0100);
        wr(8'h62, 8'h02);
        settle_check("R4 illegal IRQ2 unrouted");

        wr(8'h61, 8'h87);
        pci_int_n = 8'hFD; legacy_irq = 16'h0080;
        settle_check("R5 off bit");
        wr(8'h61, 8'h17);
        settle_check("R5 reserved bits");

        wr(8'h63, 8'h05);
        pci_int_n = 8'hF7; legacy_irq = 16'h0000;
        settle_check("R6 shared IRQ5 via D");
        check("R6 IRQ5 from D", 16'h0020);

        pci_int_n = 8'hFF; legacy_irq = 16'h8020;
        settle_check("R7 legacy blocked");
        check("R7 both claimed quiet", 16'h0000);

        int_src = 2'b10;
        settle_check("R8 source 1 on line D");
        check("R8 IRQ5 high", 16'h0020);
        int_src = 2'b00;

        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 8'h69; cfg_wdata = 8'h0A;
        pci_int_n = 8'hDF; legacy_irq = 16'h0400;
        #2 check("R9 before edge", 16'h0400);
        @(posedge clk);
        model[5] = 8'h0A;
        #2 check("R9 after edge", 16'h0400);
        @(negedge clk);
        cfg_we = 1'b0;
        pci_int_n = 8'hFF;
        #2 check("R9 R7 IRQ10 now claimed", 16'h0000);

        for (int i = 0; i < 600; i++) begin
            logic [7:0] a, d;
            a = ($urandom % 4 == 0) ? 8'($urandom) :
                (8'h60 + 8'($urandom % 4) + (($urandom % 2) ? 8'h08 : 8'h00));
            d = ($urandom % 4 == 0) ? 8'($urandom) : {4'h0, 4'($urandom)};
            @(negedge clk);
            cfg_we = ($urandom % 2 == 1);
            cfg_addr = a; cfg_wdata = d;
            pci_int_n = 8'($urandom); int_src = 2'($urandom);
            legacy_irq = 16'($urandom);
            #2 check("R3 R6 R7 R8 random before edge", expect_irq());
            @(posedge clk);
            if (cfg_we && line_of(a) >= 0) model[line_of(a)] = d;
            #2 check("R2 R4 R5 R9 random after edge", expect_irq());
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule